// File: doc/BRIEF.md
# Module Presence-Detect Store with Two-Wire Target

This block models the 256-byte descriptor store that sits on a memory module and answers a host over a two-wire serial bus. The host reads it at boot to learn how the module is organised: row and column counts, timing figures, supported latencies. The lower 128 bytes carry that descriptor, preloaded from a parameter array. The upper 128 bytes are free for the end user. A write-protect input can lock the descriptor half.

The block runs on a fast system clock. Both bus lines are sampled through synchronizers, and their edges are detected inside the block. The data line is driven only by a pull-low enable, so the open-drain pad stays outside. Three strap inputs complete the 7-bit target address, so that several modules can share one bus. The block supports byte and multi-byte writes, random reads through a pointer-setting write, and sequential reads that wrap at the end of the array.

Top module: `spd_eeprom_target`

## Requirements
- R1: The block acknowledges a transfer only when the address byte's upper seven bits are 1010 followed by straps[2], straps[1], straps[0]. Bit 0 of that byte selects read (1) or write (0). For any other address it leaves the data line released for the whole transfer.
- R2: After reset the data-line pull enable is low.
- R3: Before any write, byte 0 reads 0x80, byte 1 reads 0x08 and byte 2 reads 0x04. Bytes 36 to 61 and bytes 128 to 255 read 0xFF.
- R4: Before any write, byte 63 equals the low 8 bits of the sum of bytes 0 to 62.
- R5: In a write transfer, the first byte after the address acknowledge loads the word pointer. Each later byte is acknowledged, stored at the pointer, and then the pointer advances by one.
- R6: A read transfer returns bytes starting at the pointer and advances the pointer after each byte. The pointer wraps from 255 to 0.
- R7: When the host does not acknowledge a read byte, the block stops driving and stays released until the next START.
- R8: While write-protect is high, bytes written to addresses 0 to 127 are acknowledged but leave the stored value unchanged. Addresses 128 to 255 stay writable. While write-protect is low, every address is writable.
- R9: A START or STOP condition, which is the data line changing while the clock line is high, clears the bit counter at any point in a byte. A full transfer that follows is then handled correctly.
- R10: The block only starts pulling the data line low while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads the array from the image |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | High pulls the bus data line low |
| straps_i | input | 3 | Address straps, low three bits of the target address |
| wp_i | input | 1 | Write-protect for addresses 0 to 127 |

## Verification
A wrong bit counter or state shows at the ports within one byte. The acknowledge then lands in a data slot, or the read data comes out shifted by one bit. Either is seen at the next acknowledge sample or readback. A pointer that steps wrongly shows as the wrong byte on the very next read. A failed protection gate only shows when the affected address is read back. For that reason the bench reads every protected address it writes, directly after the write.

// File: rtl/spd_pkg.sv
// Shared constants, state type and default descriptor image for the
// presence-detect store. Assumes a 256-entry byte array.
package spd_pkg;
    localparam int SPD_DEPTH = 256;
    localparam int SPD_AW    = $clog2(SPD_DEPTH);
    localparam int CSUM_POS  = 63;

    typedef logic [7:0] image_t [SPD_DEPTH];

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_PTR,
        ST_WR,
        ST_RD
    } spd_state_t;

    // Build a default descriptor: erased fill, a handful of fields, checksum last.
    function automatic image_t default_image();
        image_t     img;
        logic [7:0] sum;
        for (int i = 0; i < SPD_DEPTH; i++) img[i] = 8'hFF;
        img[0]  = 8'h80; img[1]  = 8'h08; img[2]  = 8'h04; img[3]  = 8'h0C;
        img[4]  = 8'h08; img[5]  = 8'h02; img[6]  = 8'h40; img[7]  = 8'h00;
        img[8]  = 8'h01; img[9]  = 8'h75; img[10] = 8'h54; img[11] = 8'h00;
        img[12] = 8'h80; img[13] = 8'h10; img[14] = 8'h00; img[15] = 8'h01;
        img[16] = 8'h8F; img[17] = 8'h04; img[18] = 8'h06; img[19] = 8'h01;
        img[20] = 8'h01; img[21] = 8'h00; img[22] = 8'h0E; img[23] = 8'hA0;
        img[24] = 8'h60; img[27] = 8'h14; img[28] = 8'h0F; img[29] = 8'h14;
        img[30] = 8'h2D; img[31] = 8'h08; img[32] = 8'h15; img[33] = 8'h08;
        img[34] = 8'h15; img[35] = 8'h08; img[62] = 8'h12;
        img[126] = 8'h64; img[127] = 8'hC7;
        sum = 8'h00;
        for (int i = 0; i < CSUM_POS; i++) sum = sum + img[i];
        img[CSUM_POS] = sum;
        return img;
    endfunction
endpackage

// File: rtl/spd_bus_sync.sv
// Synchronizes the two bus lines into clk and flags clock edges and
// START/STOP conditions. Assumes the bus is far slower than clk.
module spd_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    // Shift both lines through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    // Decode edges and bus conditions from the last two synchronized samples.
    always_comb begin
        scl_s     = scl_pipe[LAST];
        sda_s     = sda_pipe[LAST];
        scl_rise  = scl_pipe[LAST] & ~scl_pipe[STAGES];
        scl_fall  = ~scl_pipe[LAST] & scl_pipe[STAGES];
        bus_start = scl_pipe[LAST] & scl_pipe[STAGES] & sda_pipe[STAGES] & ~sda_pipe[LAST];
        bus_stop  = scl_pipe[LAST] & scl_pipe[STAGES] & ~sda_pipe[STAGES] & sda_pipe[LAST];
    end
endmodule

// File: rtl/spd_store.sv
// Byte array loaded from an image at reset, with one write port gated by
// the lower-half protect and one combinational read port.
module spd_store
    import spd_pkg::*;
#(
    parameter image_t IMAGE = default_image()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_i,
    input  logic              wr_en,
    input  logic [SPD_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [SPD_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int HALF = SPD_DEPTH / 2;

    logic [7:0] mem [SPD_DEPTH];
    logic       wr_allow;

    // Protected half refuses writes while wp_i is high.
    assign wr_allow = wr_en & ~(wp_i & (int'(wr_addr) < HALF));

    // Load image on reset, otherwise accept permitted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SPD_DEPTH; i++) mem[i] <= IMAGE[i];
        end else if (wr_allow) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spd_protocol.sv
// Byte-level target state machine: address match, pointer load, writes,
// sequential reads and acknowledge handling. Drives SDA only after SCL falls.
module spd_protocol
    import spd_pkg::*;
#(
    parameter logic [3:0] PREFIX = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [2:0]        straps,
    input  logic [7:0]        rd_data,
    output logic [SPD_AW-1:0] ptr,
    output logic              wr_en,
    output logic [SPD_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              sda_pull,
    output logic [3:0]        bit_cnt
);
    spd_state_t state, nxt;
    logic       ack_ph;
    logic       mst_ack;
    logic [7:0] shreg;
    logic [7:0] txb;

    // Main sequencer: sample on SCL rise, update drive on SCL fall.
    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (!rst_n) begin
            state    <= ST_IDLE;
            nxt      <= ST_IDLE;
            ack_ph   <= 1'b0;
            mst_ack  <= 1'b0;
            shreg    <= '0;
            txb      <= '0;
            ptr      <= '0;
            wr_addr  <= '0;
            wr_data  <= '0;
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
        end else if (bus_start) begin
            state    <= ST_DEV;
            bit_cnt  <= '0;
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
        end else if (bus_stop) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (scl_rise) begin
                if (ack_ph) begin
                    mst_ack <= ~sda_s;
                end else if (bit_cnt < 4'd8) begin
                    shreg   <= {shreg[6:0], sda_s};
                    bit_cnt <= bit_cnt + 4'd1;
                end
            end else if (scl_fall) begin
                if (!ack_ph && bit_cnt == 4'd8) begin
                    ack_ph <= 1'b1;
                    case (state)
                        ST_DEV: begin
                            if (shreg[7:1] == {PREFIX, straps}) begin
                                sda_pull <= 1'b1;
                                nxt      <= shreg[0] ? ST_RD : ST_PTR;
                            end else begin
                                sda_pull <= 1'b0;
                                nxt      <= ST_IDLE;
                            end
                        end
                        ST_PTR: begin
                            sda_pull <= 1'b1;
                            ptr      <= shreg;
                            nxt      <= ST_WR;
                        end
                        ST_WR: begin
                            sda_pull <= 1'b1;
                            wr_en    <= 1'b1;
                            wr_addr  <= ptr;
                            wr_data  <= shreg;
                            ptr      <= ptr + 1'b1;
                            nxt      <= ST_WR;
                        end
                        ST_RD: begin
                            sda_pull <= 1'b0;
                            ptr      <= ptr + 1'b1;
                            nxt      <= ST_RD;
                        end
                        default: nxt <= ST_IDLE;
                    endcase
                end else if (ack_ph) begin
                    ack_ph  <= 1'b0;
                    bit_cnt <= '0;
                    state   <= nxt;
                    if (nxt == ST_RD && (state == ST_DEV || mst_ack)) begin
                        txb      <= rd_data;
                        sda_pull <= ~rd_data[7];
                    end else begin
                        sda_pull <= 1'b0;
                        if (nxt == ST_RD) state <= ST_IDLE;
                    end
                end else if (state == ST_RD && bit_cnt != 4'd0) begin
                    txb      <= {txb[6:0], 1'b0};
                    sda_pull <= ~txb[6];
                end
            end
        end
    end
endmodule

// File: rtl/spd_eeprom_target.sv
// Top level: bus synchronizer, protocol engine and byte store wired together.
// Assumes scl_i/sda_i are the resolved open-drain line levels.
module spd_eeprom_target
    import spd_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_PREFIX  = 4'b1010,
    parameter image_t     IMAGE       = default_image()
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] straps_i,
    input  logic       wp_i
);
    logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [SPD_AW-1:0] ptr, wr_addr;
    logic              wr_en;
    logic [7:0]        wr_data, rd_data;
    logic [3:0]        bit_cnt;

    spd_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    spd_protocol #(.PREFIX(DEV_PREFIX)) proto_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
        .straps(straps_i), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sda_pull(sda_pull_o),
        .bit_cnt(bit_cnt)
    );

    spd_store #(.IMAGE(IMAGE)) store_i (
        .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data)
    );
endmodule

// File: rtl/spd_eeprom_chk.sv
// Checker bound to the top: bus-drive timing, condition handling and
// pointer stepping. Assumes the synchronized view of the bus.
module spd_eeprom_chk
    import spd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              sda_pull,
    input logic [3:0]        bit_cnt,
    input logic              wr_en,
    input logic [SPD_AW-1:0] wr_addr,
    input logic [SPD_AW-1:0] ptr
);
    // R10
    pull_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R9
    start_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> bit_cnt == 4'd0);

    // R7
    stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_pull);

    // R5
    wr_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ptr == SPD_AW'(wr_addr + 1'b1));

    // R9
    bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);
endmodule

bind spd_eeprom_target spd_eeprom_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .bus_start(bus_start),
    .bus_stop(bus_stop), .sda_pull(sda_pull_o), .bit_cnt(bit_cnt),
    .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ptr)
);

// File: tb/spd_eeprom_target_tb_top.sv
module spd_eeprom_target_tb_top;
    localparam int Q = 8;
    localparam logic [2:0] STRAPS = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAPS, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAPS, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_scl = 1'b1;
    logic tb_pull = 1'b0;
    logic wp = 1'b1;
    logic dut_pull;
    logic sda_line;
    logic done = 1'b0;
    int   vectors = 0;
    int   miscompares = 0;
    logic [7:0] rbuf [64];

    always #4 clk = ~clk;
    assign sda_line = ~(tb_pull | dut_pull);

    spd_eeprom_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(tb_scl), .sda_i(sda_line),
        .sda_pull_o(dut_pull), .straps_i(STRAPS), .wp_i(wp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        tb_pull = 1'b0; wq(1);
        tb_scl = 1'b1;  wq(1);
        tb_pull = 1'b1; wq(1);
        tb_scl = 1'b0;  wq(1);
    endtask

    task automatic bus_stop();
        tb_pull = 1'b1; wq(1);
        tb_scl = 1'b1;  wq(1);
        tb_pull = 1'b0; wq(1);
    endtask

    task automatic tx_bit(input logic b);
        tb_pull = ~b; wq(1);
        tb_scl = 1'b1; wq(2);
        tb_scl = 1'b0; wq(1);
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) tx_bit(b[i]);
        tb_pull = 1'b0; wq(1);
        tb_scl = 1'b1; wq(1);
        acked = ~sda_line; wq(1);
        tb_scl = 1'b0; wq(1);
    endtask

    task automatic rx_byte(input logic give_ack, output logic [7:0] b);
        tb_pull = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq(1); tb_scl = 1'b1; wq(1);
            b[i] = sda_line; wq(1);
            tb_scl = 1'b0; wq(1);
        end
        tx_bit(~give_ack);
        tb_pull = 1'b0;
    endtask

    // Random/sequential read of n bytes from addr into rbuf.
    task automatic read_seq(input logic [7:0] addr, input int n, input string req);
        logic a;
        bus_start();
        tx_byte(DEV_W, a); check({req, " addr ack"}, a, 1);
        tx_byte(addr, a);  check({req, " ptr ack"}, a, 1);
        bus_start();
        tx_byte(DEV_R, a); check({req, " read addr ack"}, a, 1);
        for (int i = 0; i < n; i++) rx_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic write_seq(input logic [7:0] addr, input logic [7:0] d0,
                             input logic [7:0] d1, input int n, input string req);
        logic a;
        bus_start();
        tx_byte(DEV_W, a); check({req, " addr ack"}, a, 1);
        tx_byte(addr, a);  check({req, " ptr ack"}, a, 1);
        tx_byte(d0, a);    check({req, " data ack"}, a, 1);
        if (n > 1) begin tx_byte(d1, a); check({req, " data2 ack"}, a, 1); end
        bus_stop();
    endtask

    task automatic t_reset();
        check("R2 pull after reset", dut_pull, 0);
    endtask

    task automatic t_address();
        logic a;
        logic released = 1'b1;
        bus_start();
        tx_byte({4'b1010, 3'b000, 1'b0}, a);
        check("R1 foreign address nack", a, 0);
        for (int i = 0; i < 8; i++) begin tx_bit(1'b1); if (dut_pull) released = 1'b0; end
        check("R1 line released after mismatch", released, 1);
        bus_stop();
        bus_start();
        tx_byte(DEV_W, a);
        check("R1 own address ack", a, 1);
        bus_stop();
    endtask

    task automatic t_header();
        logic [7:0] sum = 8'h00;
        read_seq(8'h00, 64, "R3");
        check("R3 byte0", rbuf[0], 8'h80);
        check("R3 byte1", rbuf[1], 8'h08);
        check("R3 byte2", rbuf[2], 8'h04);
        for (int i = 36; i <= 61; i++) check("R3 reserved FF", rbuf[i], 8'hFF);
        for (int i = 0; i < 63; i++) sum = sum + rbuf[i];
        check("R4 checksum byte63", rbuf[63], sum);
        check("R7 released after nack", dut_pull, 0);
    endtask

    task automatic t_upper_and_wrap();
        read_seq(8'hFC, 5, "R6");
        for (int i = 0; i < 4; i++) check("R3 upper FF", rbuf[i], 8'hFF);
        check("R6 wrap 255 to 0", rbuf[4], 8'h80);
    endtask

    task automatic t_write();
        logic [7:0] orig;
        wp = 1'b1;
        write_seq(8'h90, 8'hA5, 8'h3C, 2, "R5");
        read_seq(8'h90, 2, "R5");
        check("R5 first byte", rbuf[0], 8'hA5);
        check("R5 pointer advanced", rbuf[1], 8'h3C);
        read_seq(8'h20, 1, "R8");
        orig = rbuf[0];
        write_seq(8'h20, ~orig, 8'h00, 1, "R8 protected");
        read_seq(8'h20, 1, "R8");
        check("R8 protected lower unchanged", rbuf[0], orig);
        wp = 1'b0;
        write_seq(8'h20, 8'h5A, 8'h00, 1, "R8 open");
        read_seq(8'h20, 1, "R8");
        check("R8 lower writable with wp low", rbuf[0], 8'h5A);
        wp = 1'b1;
    endtask

    task automatic t_abort();
        bus_start();
        tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
        read_seq(8'h02, 1, "R9");
        check("R9 read after aborted byte", rbuf[0], 8'h04);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_address();
        t_header();
        t_upper_and_wrap();
        t_write();
        t_abort();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule